// File: doc/BRIEF.md
# Per-Class Buffer Pause and Full Threshold Generator

The block watches the number of free buffer blocks held for each traffic class and turns those counts into two flow-control levels per class. The pause level asks the upstream sender to stop that class. The full level signals that the class buffer has run out. Each level has its own pair of thresholds. The level is raised when the free count drops below the raise threshold and dropped when it climbs above the release threshold. Between the two it holds, which gives hysteresis.

Two threshold sets are supplied: a pauseable set and a non-pauseable set. Each set packs four values. A per-class pauseable flag and a priority-flow-control enable decide which set each class loads. With priority flow control off, class 0 always runs on the pauseable set. Every other class is left alone: it keeps whatever thresholds it last loaded, which after reset are all zero and therefore inactive. The selected thresholds are registered, so a configuration change reaches the comparators one clock later. The level registers are not disturbed by a reload; they move only when the free count crosses the new values.

Top module: `buf_pause_gen`

## Requirements
- R1: While reset is high and on the first cycle after it, every pause and full output is 0.
- R2: A pause output becomes 1 on the clock edge after its class free count is strictly less than the pause raise threshold that class has loaded.
- R3: A pause output becomes 0 on the clock edge after its free count is strictly greater than the pause release threshold and not below the raise threshold; with the count from raise threshold to release threshold inclusive, it keeps its value.
- R4: The full output follows the rules of R2 and R3 using its own raise and release thresholds, independently of the pause output of the same class.
- R5: Each threshold set input is 4*CNT_W bits wide: bits [CNT_W-1:0] hold the pause raise threshold, [2*CNT_W-1:CNT_W] the pause release threshold, [3*CNT_W-1:2*CNT_W] the full raise threshold, and [4*CNT_W-1:3*CNT_W] the full release threshold. Free counts are packed with class c at bits [(c+1)*CNT_W-1:c*CNT_W].
- R6: With pfc_en at 0, class 0 loads the pauseable set on every clock, whatever its pauseable flag says.
- R7: With pfc_en at 0, class 1 loads nothing. From reset its thresholds are all zero, so its outputs stay 0 for every count. After priority flow control has been on, class 1 keeps the last set it loaded, even if the set inputs or its flag change.
- R8: With pfc_en at 1, each class loads the pauseable set when its pauseable flag (bit c) is 1 and the non-pauseable set when it is 0.
- R9: A change to pfc_en, a flag or a set input reaches the threshold registers on the next edge and first affects the outputs on the edge after that. The outputs keep their state through the reload.
- R10: When a release threshold is configured at or below its raise threshold, a count below the raise threshold still raises the output; raising takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pfc_en | input | 1 | Priority flow control enable |
| pauseable | input | NUM_CLS | Per-class pauseable flag, bit c for class c |
| free_cnt | input | NUM_CLS*CNT_W | Free block counts, packed per class |
| thr_pauseable | input | 4*CNT_W | Pauseable threshold set |
| thr_nonpause | input | 4*CNT_W | Non-pauseable threshold set |
| pause_o | output | NUM_CLS | Per-class pause level |
| full_o | output | NUM_CLS | Per-class full level |

## Verification
The hardest state to reach from the ports is class 1 running on stale thresholds. Its registers only move while priority flow control is on, so it can hold values that no longer match either set input or its flag. The bench first enables priority flow control with the non-pauseable set selected for class 1. It then clears the enable, rewrites both sets and flips the flag, and sweeps the class 1 count through the old crossing points. A long random phase also toggles the enable often, which keeps producing fresh stale states that a bench-side model tracks.

// File: rtl/buf_pause_pkg.sv
package buf_pause_pkg;

    // Field slots inside a packed threshold set (position is part of the interface)
    localparam int unsigned NUM_FIELDS = 4;
    localparam int unsigned F_PAUSE_ON  = 0;
    localparam int unsigned F_PAUSE_OFF = 1;
    localparam int unsigned F_FULL_ON   = 2;
    localparam int unsigned F_FULL_OFF  = 3;

    typedef enum logic {
        SET_PAUSEABLE = 1'b0,
        SET_NONPAUSE  = 1'b1
    } set_sel_e;

    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_RAISE = 2'd1,
        ACT_DROP  = 2'd2
    } hyst_act_e;

    typedef struct packed {
        logic pause;
        logic full;
    } cls_lvl_t;

    // Set chosen by a class whenever it is allowed to load
    function automatic set_sel_e pick_set(input logic pfc_on, input logic flag);
        if (pfc_on && !flag) return SET_NONPAUSE;
        return SET_PAUSEABLE;
    endfunction

    // Raising wins over dropping when the window is inverted
    function automatic hyst_act_e hyst_decide(input logic under_on, input logic over_off);
        if (under_on)  return ACT_RAISE;
        if (over_off)  return ACT_DROP;
        return ACT_HOLD;
    endfunction

endpackage

// File: rtl/thr_select.sv
module thr_select
    import buf_pause_pkg::*;
#(
    parameter int unsigned CNT_W = 8,
    parameter bit          GATED = 1'b0,
    localparam int unsigned SET_W = NUM_FIELDS * CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pfc_en,
    input  logic             flag,
    input  logic [SET_W-1:0] set_p,
    input  logic [SET_W-1:0] set_n,
    output logic [SET_W-1:0] thr_q
);

    set_sel_e         sel;
    logic             load;
    logic [SET_W-1:0] nxt;

    always_comb begin
        sel = pick_set(pfc_en, flag);
        nxt = (sel == SET_NONPAUSE) ? set_n : set_p;
    end

    generate
        if (GATED) begin : g_gated
            assign load = pfc_en;
        end else begin : g_free
            assign load = 1'b1;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            thr_q <= '0;
        end else if (load) begin
            thr_q <= nxt;
        end
    end

    generate
        if (GATED) begin : g_chk_gated
            // R7
            freeze_when_off_chk: assert property (@(posedge clk) disable iff (rst)
                !pfc_en |=> $stable(thr_q));
        end else begin : g_chk_free
            // R6
            base_set_when_off_chk: assert property (@(posedge clk) disable iff (rst)
                !pfc_en |=> (thr_q == $past(set_p)));
        end
    endgenerate

    // R8
    flag_picks_p_chk: assert property (@(posedge clk) disable iff (rst)
        (pfc_en && flag) |=> (thr_q == $past(set_p)));
    // R8
    flag_picks_n_chk: assert property (@(posedge clk) disable iff (rst)
        (pfc_en && !flag) |=> (thr_q == $past(set_n)));

endmodule

// File: rtl/hyst_level.sv
module hyst_level
    import buf_pause_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] free_cnt,
    input  logic [CNT_W-1:0] thr_on,
    input  logic [CNT_W-1:0] thr_off,
    output logic             lvl
);

    hyst_act_e act;

    always_comb begin
        act = hyst_decide(free_cnt < thr_on, free_cnt > thr_off);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl <= 1'b0;
        end else begin
            unique case (act)
                ACT_RAISE: lvl <= 1'b1;
                ACT_DROP:  lvl <= 1'b0;
                default:   lvl <= lvl;
            endcase
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> !lvl);
    // R2
    raise_below_chk: assert property (@(posedge clk) disable iff (rst)
        (free_cnt < thr_on) |=> lvl);
    // R3
    drop_above_chk: assert property (@(posedge clk) disable iff (rst)
        ((free_cnt >= thr_on) && (free_cnt > thr_off)) |=> !lvl);
    // R3
    hold_window_chk: assert property (@(posedge clk) disable iff (rst)
        ((free_cnt >= thr_on) && (free_cnt <= thr_off)) |=> $stable(lvl));
    // R10
    inverted_raise_chk: assert property (@(posedge clk) disable iff (rst)
        ((thr_off <= thr_on) && (free_cnt < thr_on)) |=> lvl);

endmodule

// File: rtl/class_unit.sv
module class_unit
    import buf_pause_pkg::*;
#(
    parameter int unsigned CNT_W = 8,
    parameter bit          GATED = 1'b0,
    localparam int unsigned SET_W = NUM_FIELDS * CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pfc_en,
    input  logic             flag,
    input  logic [CNT_W-1:0] free_cnt,
    input  logic [SET_W-1:0] set_p,
    input  logic [SET_W-1:0] set_n,
    output cls_lvl_t         lvl
);

    logic [SET_W-1:0] thr;
    logic [CNT_W-1:0] fld [NUM_FIELDS];

    thr_select #(.CNT_W(CNT_W), .GATED(GATED)) u_sel (
        .clk    (clk),
        .rst    (rst),
        .pfc_en (pfc_en),
        .flag   (flag),
        .set_p  (set_p),
        .set_n  (set_n),
        .thr_q  (thr)
    );

    generate
        for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_fld
            assign fld[f] = thr[f*CNT_W +: CNT_W];
        end
    endgenerate

    hyst_level #(.CNT_W(CNT_W)) u_pause (
        .clk      (clk),
        .rst      (rst),
        .free_cnt (free_cnt),
        .thr_on   (fld[F_PAUSE_ON]),
        .thr_off  (fld[F_PAUSE_OFF]),
        .lvl      (lvl.pause)
    );

    hyst_level #(.CNT_W(CNT_W)) u_full (
        .clk      (clk),
        .rst      (rst),
        .free_cnt (free_cnt),
        .thr_on   (fld[F_FULL_ON]),
        .thr_off  (fld[F_FULL_OFF]),
        .lvl      (lvl.full)
    );

endmodule

// File: rtl/buf_pause_gen.sv
module buf_pause_gen
    import buf_pause_pkg::*;
#(
    parameter int unsigned CNT_W   = 8,
    parameter int unsigned NUM_CLS = 2,
    localparam int unsigned SET_W  = NUM_FIELDS * CNT_W,
    localparam int unsigned FREE_W = NUM_CLS * CNT_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pfc_en,
    input  logic [NUM_CLS-1:0] pauseable,
    input  logic [FREE_W-1:0]  free_cnt,
    input  logic [SET_W-1:0]   thr_pauseable,
    input  logic [SET_W-1:0]   thr_nonpause,
    output logic [NUM_CLS-1:0] pause_o,
    output logic [NUM_CLS-1:0] full_o
);

    cls_lvl_t lvl [NUM_CLS];

    generate
        for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
            class_unit #(
                .CNT_W (CNT_W),
                .GATED (c != 0)
            ) u_cls (
                .clk      (clk),
                .rst      (rst),
                .pfc_en   (pfc_en),
                .flag     (pauseable[c]),
                .free_cnt (free_cnt[c*CNT_W +: CNT_W]),
                .set_p    (thr_pauseable),
                .set_n    (thr_nonpause),
                .lvl      (lvl[c])
            );
            assign pause_o[c] = lvl[c].pause;
            assign full_o[c]  = lvl[c].full;
        end
    endgenerate

endmodule

// File: tb/buf_pause_gen_tb.sv
module buf_pause_gen_tb;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 8;
    localparam int NUM_CLS    = 2;
    localparam int WATCHDOG   = 150000;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic                    pfc_en = 1'b0;
    logic [NUM_CLS-1:0]      pauseable = '0;
    logic [CNT_W-1:0]        f0 = '0, f1 = '0;
    logic [CNT_W-1:0]        tp [4];
    logic [CNT_W-1:0]        tn [4];
    logic [NUM_CLS*CNT_W-1:0] free_cnt;
    logic [4*CNT_W-1:0]      thr_pauseable, thr_nonpause;
    logic [NUM_CLS-1:0]      pause_o, full_o;

    // R5 packing
    assign free_cnt      = {f1, f0};
    assign thr_pauseable = {tp[3], tp[2], tp[1], tp[0]};
    assign thr_nonpause  = {tn[3], tn[2], tn[1], tn[0]};

    always #(CLK_PERIOD/2) clk = ~clk;

    buf_pause_gen #(.CNT_W(CNT_W), .NUM_CLS(NUM_CLS)) u_dut (
        .clk           (clk),
        .rst           (rst),
        .pfc_en        (pfc_en),
        .pauseable     (pauseable),
        .free_cnt      (free_cnt),
        .thr_pauseable (thr_pauseable),
        .thr_nonpause  (thr_nonpause),
        .pause_o       (pause_o),
        .full_o        (full_o)
    );

    int    n_vec = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;
    string req   = "R1";

    logic [CNT_W-1:0] m_thr [2][4];
    logic [1:0]       m_pause, m_full;

    task automatic model_edge();
        logic [1:0] np, nf;
        for (int c = 0; c < 2; c++) begin
            logic [CNT_W-1:0] fr;
            fr = (c == 0) ? f0 : f1;
            np[c] = (fr < m_thr[c][0]) ? 1'b1 : (fr > m_thr[c][1]) ? 1'b0 : m_pause[c];
            nf[c] = (fr < m_thr[c][2]) ? 1'b1 : (fr > m_thr[c][3]) ? 1'b0 : m_full[c];
        end
        if (rst) begin
            m_pause = '0;
            m_full  = '0;
            for (int c = 0; c < 2; c++)
                for (int k = 0; k < 4; k++) m_thr[c][k] = '0;
        end else begin
            m_pause = np;
            m_full  = nf;
            for (int k = 0; k < 4; k++) begin
                m_thr[0][k] = (pfc_en && !pauseable[0]) ? tn[k] : tp[k];
                if (pfc_en) m_thr[1][k] = pauseable[1] ? tp[k] : tn[k];
            end
        end
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        n_vec++;
        if (pause_o !== m_pause || full_o !== m_full) begin
            n_bad++;
            $display("FAIL %s: pause=%b full=%b expected pause=%b full=%b (f0=%0d f1=%0d)",
                     req, pause_o, full_o, m_pause, m_full, f0, f1);
        end
    endtask

    task automatic set_p(input int a, input int b, input int c, input int d);
        tp[0] = a[CNT_W-1:0]; tp[1] = b[CNT_W-1:0]; tp[2] = c[CNT_W-1:0]; tp[3] = d[CNT_W-1:0];
    endtask

    task automatic set_n(input int a, input int b, input int c, input int d);
        tn[0] = a[CNT_W-1:0]; tn[1] = b[CNT_W-1:0]; tn[2] = c[CNT_W-1:0]; tn[3] = d[CNT_W-1:0];
    endtask

    task automatic sweep(input bit cls1);
        for (int v = 110; v >= 0; v--) begin
            if (cls1) f1 = v[CNT_W-1:0]; else f0 = v[CNT_W-1:0];
            step();
        end
        for (int v = 0; v <= 110; v++) begin
            if (cls1) f1 = v[CNT_W-1:0]; else f0 = v[CNT_W-1:0];
            step();
        end
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < 2; c++)
            for (int k = 0; k < 4; k++) m_thr[c][k] = '0;
        m_pause = '0; m_full = '0;
        set_p(40, 60, 10, 20);
        set_n(70, 90, 30, 50);
        @(negedge clk);

        // R1: reset with counts that would otherwise raise everything
        req = "R1";
        rst = 1'b1; f0 = 0; f1 = 0; pfc_en = 1'b1; pauseable = 2'b11;
        repeat (3) step();
        rst = 1'b0; pfc_en = 1'b0; pauseable = 2'b00; f0 = 100; f1 = 0;
        step();

        // R7: class 1 never loaded since reset, stays low at any count
        req = "R7";
        sweep(1'b1);

        // R2/R3/R4 and R6: class 0 on the pauseable set, flag ignored
        req = "R2 R3 R4 R6";
        sweep(1'b0);
        pauseable = 2'b11;
        sweep(1'b0);

        // R8: priority flow control on, all flag combinations
        req = "R8";
        pfc_en = 1'b1;
        for (int m = 0; m < 4; m++) begin
            pauseable = m[1:0];
            step();
            sweep(1'b0);
            sweep(1'b1);
        end

        // R7: freeze class 1 on the non-pauseable set, then change everything
        req = "R7";
        pauseable = 2'b00; step(); step();
        pfc_en = 1'b0; pauseable = 2'b10;
        set_p(5, 8, 3, 4);
        set_n(100, 105, 95, 100);
        step();
        sweep(1'b1);
        set_p(40, 60, 10, 20);
        set_n(70, 90, 30, 50);

        // R9: reload latency, outputs held through reload
        req = "R9";
        f0 = 30; step(); step(); step();
        set_p(50, 60, 10, 20);
        step();            // thresholds reload, output still old
        step();            // output reflects new raise threshold
        set_p(20, 25, 10, 20);
        step();
        step();
        f0 = 26; step(); step();

        // R10: release at or below raise threshold
        req = "R10";
        set_p(50, 30, 40, 40);
        step();
        sweep(1'b0);

        // R5: random configurations and counts, layout exercised field by field
        req = "R5";
        for (int i = 0; i < 3000; i++) begin
            if (($urandom % 8) == 0) pfc_en = ~pfc_en;
            if (($urandom % 6) == 0) pauseable = 2'($urandom);
            if (($urandom % 10) == 0) set_p($urandom % 64, $urandom % 64, $urandom % 64, $urandom % 64);
            if (($urandom % 10) == 0) set_n($urandom % 64, $urandom % 64, $urandom % 64, $urandom % 64);
            f0 = CNT_W'($urandom % 72);
            f1 = CNT_W'($urandom % 72);
            if (i == 1500) rst = 1'b1;
            if (i == 1502) rst = 1'b0;
            step();
        end

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule